// File: doc/BRIEF.md
# Loop-Period Snapping Wait Unit

This unit gives one processor core a cycle-exact loop rate even when the loop body contains accesses to shared memory whose latency varies. Software first programs a period of M clock cycles. The cycle in which the period is programmed becomes the anchor of a grid of boundaries, one every M cycles. Each later wait command stalls the core until the next grid boundary, so the loop always leaves the wait at some multiple k of M after the anchor. This differs from a wait for one absolute count, which has a single target.

The unit offers two ways to use it. In the first, the core issues a separate wait command at the end of the loop body. In the second, the snap is fused onto a pending shared-memory access. The unit arms on the access request, waits for the memory side to report completion, and then holds the release until the next boundary. No extra wait instruction is then needed in the loop.

Each release is a one-cycle pulse. If the loop body ran past the boundary it was meant to meet, a sticky flag records this, and it stays set until the period is programmed again. The period should be larger than the 16-cycle rotation of the shared memory. For example, 40 cycles at a 200 MHz clock gives a 200 ns loop.

Top module: `loop_snap_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `overrun_o` are low, and no release happens until a command is issued.
- R2: A `set_period_i` pulse accepted in cycle b loads `period_i` as M and anchors the grid so that the boundaries are exactly the cycles b + k·M.
- R3: A `wait_i` issued in idle cycle c drives `done_o` high for exactly one cycle, in the first boundary cycle strictly after c. `busy_o` is high from c+1 through that release cycle.
- R4: A wait issued in a cycle that is itself a boundary, including the cycle in which the period is programmed, is released a full M cycles later.
- R5: A `mem_req_i` issued while idle arms the attached mode. The release comes in the first boundary cycle strictly after the cycle in which `mem_done_i` is high. `mem_done_i` may arrive in the same cycle as the request.
- R6: When a loop body is shorter than M, consecutive releases are exactly M cycles apart, whatever the memory latency inside the body.
- R7: If a command is issued in a cycle at or after the previous release plus M (the previous release being the anchor cycle right after programming), `overrun_o` rises from the next cycle. It stays high until the next accepted `set_period_i`, which clears it.
- R8: With M = 0, a wait releases in the cycle right after it is issued, an attached access releases in the cycle after `mem_done_i`, and `overrun_o` is never set.
- R9: While `busy_o` is high, `wait_i`, `mem_req_i` and `set_period_i` have no effect. `mem_done_i` has no effect unless an attached access is pending. When `wait_i` and `mem_req_i` are high in the same idle cycle, the standalone wait is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_period_i | input | 1 | Program period and anchor the grid (idle only) |
| period_i | input | PER_W | Period M in clock cycles |
| wait_i | input | 1 | Standalone snap command |
| mem_req_i | input | 1 | Snap attached to a pending shared-memory access |
| mem_done_i | input | 1 | Shared-memory access completion |
| busy_o | output | 1 | Core is stalled in the unit |
| done_o | output | 1 | One-cycle release pulse on a grid boundary |
| overrun_o | output | 1 | Sticky: a loop body missed its boundary |

## Verification
The bench goes after a wait that lands exactly on a boundary. A design that treats "on a boundary" as "already there" would release one cycle later instead of a full period later. The bench also fuses a wait with reprogramming in the same cycle, which exposes a grid anchored one cycle off, because every later release would then shift by one. A run of attached accesses with varying latency shows whether releases keep an exact period or drift with the memory. Commands injected while busy, a stray completion while idle, and periods of zero and one catch a design that rearms, moves its grid, raises a false overrun, or loses the sticky flag before reprogramming.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ATTACH,
    ST_SNAP
  } snap_state_e;
endpackage

// File: rtl/snap_phase.sv
module snap_phase #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PER_W-1:0] period_i,
  output logic             on_grid_o,
  output logic             zero_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] per_q, ph_q;

  // ph_q is the grid phase of the current cycle; the load cycle has phase 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      ph_q  <= '0;
    end else if (load_i) begin
      per_q <= period_i;
      ph_q  <= (period_i > ONE) ? ONE : '0;
    end else if (per_q != '0) begin
      ph_q  <= (ph_q == per_q - ONE) ? '0 : ph_q + ONE;
    end
  end

  assign on_grid_o = (ph_q == '0);
  assign zero_o    = (per_q == '0);

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != '0) |-> (ph_q < per_q)); // R2
  AST_ZERO_ON_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> on_grid_o); // R8
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wait_i,
  input  logic req_i,
  input  logic mem_done_i,
  input  logic on_grid_i,
  input  logic zero_i,
  output logic load_o,
  output logic busy_o,
  output logic done_o,
  output logic overrun_o
);
  snap_state_e state_q;
  logic        missed_q, ovr_q;
  logic        idle, issue;

  assign idle   = (state_q == ST_IDLE);
  assign load_o = idle & set_i;
  assign issue  = idle & (wait_i | req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      missed_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (set_i) begin
            missed_q <= 1'b0;
            ovr_q    <= 1'b0;
          end else begin
            if (on_grid_i) missed_q <= 1'b1;
            // a boundary passed since the last release, or now is one
            if (issue && !zero_i && (missed_q || on_grid_i)) ovr_q <= 1'b1;
          end
          if (wait_i)     state_q <= ST_SNAP;
          else if (req_i) state_q <= mem_done_i ? ST_SNAP : ST_ATTACH;
        end
        ST_ATTACH: if (mem_done_i) state_q <= ST_SNAP;
        ST_SNAP: if (on_grid_i) begin
          state_q  <= ST_IDLE;
          missed_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = !idle;
  assign done_o    = (state_q == ST_SNAP) & on_grid_i;
  assign overrun_o = ovr_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wait_i) |=> busy_o); // R3
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !load_o) |=> overrun_o); // R7
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !overrun_o); // R7
  AST_ATTACH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ATTACH && !mem_done_i) |=> (state_q == ST_ATTACH && !done_o)); // R5
endmodule

// File: rtl/loop_snap_unit.sv
module loop_snap_unit #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_period_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             wait_i,
  input  logic             mem_req_i,
  input  logic             mem_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             overrun_o
);
  logic load, on_grid, zero;

  snap_phase #(.PER_W(PER_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .period_i  (period_i),
    .on_grid_o (on_grid),
    .zero_o    (zero)
  );

  snap_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_period_i),
    .wait_i     (wait_i),
    .req_i      (mem_req_i),
    .mem_done_i (mem_done_i),
    .on_grid_i  (on_grid),
    .zero_i     (zero),
    .load_o     (load),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .overrun_o  (overrun_o)
  );

  AST_ZERO_NO_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero && !overrun_o && !load) |=> !overrun_o); // R8
endmodule

// File: tb/loop_snap_unit_bench.sv
module loop_snap_unit_bench;
  localparam int PER_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic set_period = 1'b0, wait_c = 1'b0, mem_req = 1'b0, mem_done = 1'b0;
  logic [PER_W-1:0] period = '0;
  logic busy, done, ovr;

  always #10 clk = ~clk; // 50 MHz

  loop_snap_unit #(.PER_W(PER_W)) u_loop_snap_unit (
    .clk_i(clk), .rst_ni(rst_n), .set_period_i(set_period), .period_i(period),
    .wait_i(wait_c), .mem_req_i(mem_req), .mem_done_i(mem_done),
    .busy_o(busy), .done_o(done), .overrun_o(ovr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // scoreboard
  int    exp_cyc[$];
  bit    exp_ovr[$];
  string exp_tag[$];
  int    last_done = 0;

  // reference model state
  int base = 0, per = 0, rel = 0;
  bit ovr_m = 1'b0;

  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected release at cycle %0d, expected none", cyc);
      end else begin
        int e_c; bit e_o; string t;
        e_c = exp_cyc.pop_front(); e_o = exp_ovr.pop_front(); t = exp_tag.pop_front();
        if (cyc != e_c || ovr != e_o) begin
          fails++;
          $display("FAIL %s: release cycle/overrun %0d/%0b, expected %0d/%0b", t, cyc, ovr, e_c, e_o);
        end
      end
      last_done = cyc;
    end
  end

  function automatic int next_bound(int from);
    if (per == 0) return from + 1;
    return from + per - ((from - base) % per);
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic program_period(int p, bit with_wait, string tag);
    set_period = 1'b1; period = PER_W'(p);
    base = cyc; rel = cyc; per = p; ovr_m = 1'b0;
    if (with_wait) begin
      wait_c = 1'b1;
      rel = next_bound(cyc);
      exp_cyc.push_back(rel); exp_ovr.push_back(1'b0); exp_tag.push_back(tag);
    end
    @(negedge clk);
    set_period = 1'b0; wait_c = 1'b0;
    if (with_wait) while (cyc <= rel) @(negedge clk);
  endtask

  task automatic do_wait(bit poke, string tag);
    int c, e;
    c = cyc;
    if (per != 0 && c >= rel + per) ovr_m = 1'b1;
    e = next_bound(c);
    exp_cyc.push_back(e); exp_ovr.push_back(ovr_m); exp_tag.push_back(tag);
    rel = e;
    wait_c = 1'b1;
    @(negedge clk);
    wait_c = 1'b0;
    if (poke) begin
      // commands while busy must be ignored (R9)
      wait_c = 1'b1; mem_req = 1'b1; mem_done = 1'b1; set_period = 1'b1; period = PER_W'(7);
      @(negedge clk);
      wait_c = 1'b0; mem_req = 1'b0; mem_done = 1'b0; set_period = 1'b0;
    end
    while (cyc <= e) @(negedge clk);
  endtask

  task automatic do_attach(int lat, string tag);
    int c, d, e;
    c = cyc;
    if (per != 0 && c >= rel + per) ovr_m = 1'b1;
    mem_req = 1'b1;
    if (lat == 0) mem_done = 1'b1;
    d = c;
    @(negedge clk);
    mem_req = 1'b0; mem_done = 1'b0;
    if (lat > 0) begin
      repeat (lat - 1) @(negedge clk);
      d = cyc;
      mem_done = 1'b1;
      @(negedge clk);
      mem_done = 1'b0;
    end
    e = next_bound(d);
    exp_cyc.push_back(e); exp_ovr.push_back(ovr_m); exp_tag.push_back(tag);
    rel = e;
    while (cyc <= e) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 overrun", ovr, 0);
    idle(10);

    // R2 / R3: grid anchored at programming cycle
    program_period(40, 1'b0, "R2");
    idle(5);
    do_wait(1'b0, "R2");
    idle(3);
    do_wait(1'b0, "R3");
    do_wait(1'b1, "R9");         // pokes while busy, grid must not move
    do_wait(1'b0, "R9");

    // R4: program and wait in the same cycle -> full period
    program_period(40, 1'b1, "R4");
    // R4/R7: issue exactly on the next boundary -> full period + overrun
    while (cyc != rel + per) @(negedge clk);
    do_wait(1'b0, "R4");
    do_wait(1'b0, "R7");         // on time, overrun stays sticky
    idle(100);
    do_wait(1'b0, "R7");         // several boundaries missed
    program_period(40, 1'b0, "R7");
    check("R7 cleared by program", ovr, 0);

    // R8: zero period
    program_period(0, 1'b0, "R8");
    idle(30);
    do_wait(1'b0, "R8");
    do_attach(0, "R8");
    do_attach(4, "R8");
    check("R8 no overrun", ovr, 0);

    // period 1: every cycle is a boundary
    program_period(1, 1'b0, "R7");
    do_wait(1'b0, "R7");

    // R5 / R6: attached loop, variable latency, fixed rate
    program_period(20, 1'b0, "R5");
    do_attach(3, "R5");
    begin
      int lats[5] = '{11, 6, 0, 9, 16};
      for (int i = 0; i < 5; i++) begin
        int prev;
        prev = last_done;
        do_attach(lats[i], "R5");
        check("R6 loop period", last_done - prev, 20);
      end
    end

    // R9: stray completion while idle
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    check("R9 idle mem_done busy", busy, 0);
    idle(45);

    // R9: wait beats mem_req in the same cycle (release follows the wait, not a completion)
    begin
      int e;
      e = next_bound(cyc);
      if (cyc >= rel + per) ovr_m = 1'b1;
      exp_cyc.push_back(e); exp_ovr.push_back(ovr_m); exp_tag.push_back("R9");
      rel = e;
      wait_c = 1'b1; mem_req = 1'b1;
      @(negedge clk);
      wait_c = 1'b0; mem_req = 1'b0;
      while (cyc <= e) @(negedge clk);
    end

    idle(60);
    check("R3 all releases seen", exp_cyc.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule